// File: doc/BRIEF.md
# EEPROM Loader Control-Status Register

This block is a single 32-bit memory-mapped register that sits between software and an engine that reads an I2C EEPROM. Software writes a 16-bit EEPROM start offset and issues a start command, or an abort command, in the same word. The block turns each command into a one-clock pulse towards the engine and passes the offset along. The engine's own logic is outside the block.

The engine reports back through a busy level, a done strobe, and four error event strobes: checksum mismatch, a 32-bit word cut short, a 22-bit word cut short, and a missing acknowledge. The register shows whether a sequence is running, whether the last one ended cleanly, and which errors have occurred. The success flag holds until the next accepted start. The error flags stay set until software reads the register.

Register reads are synchronous: the data appears on the cycle after the read enable and shows the state before that edge.

Top module: `eeprom_ldr_csr`

## Requirements
- R1: Bits 15:0 hold the EEPROM start offset. The field resets to 0, is written by every register write, reads back as written, and is driven on `start_offset`.
- R2: A write with bit 16 set and bit 20 clear, while the block is idle, produces a one-cycle `start_pulse` in the cycle after the write. Idle means the sequence flag is clear and `eng_busy` is low.
- R3: A write with bit 20 set produces a one-cycle `abort_pulse` in the cycle after the write and ends the running sequence. Abort takes priority, so a start in the same write is ignored.
- R4: Bits 31:27, 20, 19:17 and 16 always read as 0.
- R5: Bit 22 (in progress) reads 1 while a sequence is running or `eng_busy` is high. A sequence starts at an accepted start and ends at `eng_done` or an abort.
- R6: Bit 21 (success) sets when `eng_done` ends a running sequence during which no error strobe arrived, including one in the done cycle. It stays set until the next accepted start clears it.
- R7: Bits 23 (checksum), 24 (32-bit short), 25 (22-bit short) and 26 (no acknowledge) are set by the strobes `evt_chksum`, `evt_short32`, `evt_short22` and `evt_nack`. Each stays set until a register read clears it.
- R8: An error strobe that arrives in the same cycle as a register read leaves its flag set after that read.
- R9: A start written while a sequence is in progress is ignored: no pulse is produced and success is not cleared.
- R10: `reg_rdata` shows the packed register in the cycle after `reg_rd_en` and is 0 in any other cycle, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine sequence-complete strobe |
| evt_chksum | input | 1 | Checksum mismatch strobe |
| evt_short32 | input | 1 | 32-bit word cut short strobe |
| evt_short22 | input | 1 | 22-bit word cut short strobe |
| evt_nack | input | 1 | Missing acknowledge strobe |
| start_pulse | output | 1 | One-cycle start command to the engine |
| abort_pulse | output | 1 | One-cycle abort command to the engine |
| start_offset | output | 16 | EEPROM start offset to the engine |

## Verification
The bench targets these corner cases:

- **Error strobe during a read.** A design that clears the flag unconditionally on a read would lose the error, and a later read would show 0.
- **Start and abort in one write.** A design without abort priority would emit a start pulse.
- **Start while running.** A design that does not gate the start would pulse again and wipe a held success flag.
- **Error strobe in the same cycle as done.** A design that looks only at earlier errors would report a false success.

Random traffic covers the remaining interleavings of writes, reads, busy and strobes.

// File: rtl/eeprom_ldr_pkg.sv
// Package: bit positions and widths of the EEPROM loader control-status word.
// Assumes a 32-bit register with the command and status fields at fixed positions.
package eeprom_ldr_pkg;
    localparam int REG_W      = 32;
    localparam int OFS_W      = 16;
    localparam int NUM_ERR    = 4;
    localparam int BIT_START  = 16;
    localparam int BIT_ABORT  = 20;
    localparam int BIT_OK     = 21;
    localparam int BIT_RUN    = 22;
    localparam int BIT_ERR_LO = 23;

    // Index of each error flag inside the error vector.
    typedef enum logic [1:0] {
        ERR_CHKSUM  = 2'd0,
        ERR_SHORT32 = 2'd1,
        ERR_SHORT22 = 2'd2,
        ERR_NACK    = 2'd3
    } err_idx_e;
endpackage

// File: rtl/ldr_cmd_ctrl.sv
// Command decode: turns start/abort write bits into one-cycle pulses and tracks
// the running-sequence flag. Assumes wr_start/wr_abort are valid only while the
// write strobe is high (already qualified by the caller).
module ldr_cmd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_abort,
    input  logic eng_busy,
    input  logic eng_done,
    output logic start_acc,
    output logic run_q,
    output logic start_pulse,
    output logic abort_pulse
);
    logic idle;

    // Start is accepted only when idle and no abort shares the write.
    always_comb begin
        idle      = !run_q && !eng_busy;
        start_acc = wr_start && !wr_abort && idle;
    end

    // Registers the pulses and the running-sequence flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            start_pulse <= start_acc;
            abort_pulse <= wr_abort;
            if (start_acc)
                run_q <= 1'b1;
            else if (wr_abort || eng_done)
                run_q <= 1'b0;
        end
    end

    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(!run_q && !eng_busy) && run_q));
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_abort_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!start_pulse && !run_q));
    assert_busy_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q || eng_busy) |=> !start_pulse);
endmodule

// File: rtl/ldr_status.sv
// Status tracking: the success flag and the clear-on-read sticky error flags.
// Assumes start_acc is a one-cycle accepted-start indication and run_q is the
// running-sequence flag from the command decoder.
module ldr_status #(
    parameter int NUM_ERR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               start_acc,
    input  logic               run_q,
    input  logic               eng_done,
    input  logic [NUM_ERR-1:0] evt,
    output logic               ok_q,
    output logic [NUM_ERR-1:0] err_q
);
    logic seq_err_q;
    logic any_evt;

    // Any error strobe in the current cycle.
    always_comb any_evt = |evt;

    // Tracks errors in the current sequence and the success flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_err_q <= 1'b0;
            ok_q      <= 1'b0;
        end else if (start_acc) begin
            seq_err_q <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            seq_err_q <= seq_err_q || any_evt;
            if (eng_done && run_q && !seq_err_q && !any_evt)
                ok_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        // One sticky flag: set by its strobe, cleared by a read without strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_q[i] <= 1'b0;
            else
                err_q[i] <= (err_q[i] && !rd_en) || evt[i];
        end

        assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> err_q[i]);
        assert_err_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !evt[i]) |=> !err_q[i]);
        assert_err_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && evt[i]) |=> err_q[i]);
    end

    assert_ok_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !ok_q);
    assert_ok_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_q) |-> $past(eng_done && run_q && !any_evt));
endmodule

// File: rtl/eeprom_ldr_csr.sv
// Top: the 32-bit EEPROM loader control-status register. It holds the offset,
// decodes commands, gathers status and returns registered read data.
// Assumes a single-cycle write strobe and a read port with one cycle of latency.
module eeprom_ldr_csr
    import eeprom_ldr_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int OFFS_W = OFS_W,
    parameter int ERR_N  = NUM_ERR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              evt_chksum,
    input  logic              evt_short32,
    input  logic              evt_short22,
    input  logic              evt_nack,
    output logic              start_pulse,
    output logic              abort_pulse,
    output logic [OFFS_W-1:0] start_offset
);
    localparam int ERR_HI = BIT_ERR_LO + ERR_N - 1;

    logic [OFFS_W-1:0] offs_q;
    logic              wr_start;
    logic              wr_abort;
    logic              start_acc;
    logic              run_q;
    logic              ok_q;
    logic [ERR_N-1:0]  err_q;
    logic [ERR_N-1:0]  evt;
    logic [DATA_W-1:0] packed_word;

    // Qualifies the command bits with the write strobe and gathers the strobes.
    always_comb begin
        wr_start = reg_wr_en && reg_wdata[BIT_START];
        wr_abort = reg_wr_en && reg_wdata[BIT_ABORT];
        evt = '0;
        evt[ERR_CHKSUM]  = evt_chksum;
        evt[ERR_SHORT32] = evt_short32;
        evt[ERR_SHORT22] = evt_short22;
        evt[ERR_NACK]    = evt_nack;
    end

    ldr_cmd_ctrl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start    (wr_start),
        .wr_abort    (wr_abort),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .start_acc   (start_acc),
        .run_q       (run_q),
        .start_pulse (start_pulse),
        .abort_pulse (abort_pulse)
    );

    ldr_status #(.NUM_ERR(ERR_N)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (reg_rd_en),
        .start_acc (start_acc),
        .run_q     (run_q),
        .eng_done  (eng_done),
        .evt       (evt),
        .ok_q      (ok_q),
        .err_q     (err_q)
    );

    // Persistent offset field, written by every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offs_q <= '0;
        else if (reg_wr_en)
            offs_q <= reg_wdata[OFFS_W-1:0];
    end

    // Packs the readable fields; command and unused bits stay zero.
    always_comb begin
        packed_word                       = '0;
        packed_word[OFFS_W-1:0]           = offs_q;
        packed_word[BIT_OK]               = ok_q;
        packed_word[BIT_RUN]              = run_q || eng_busy;
        packed_word[ERR_HI:BIT_ERR_LO]    = err_q;
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else
            reg_rdata <= reg_rd_en ? packed_word : '0;
    end

    assign start_offset = offs_q;

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:ERR_HI+1] == '0) && (reg_rdata[BIT_ABORT:BIT_START] == '0));
    assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == '0));
    assert_offset_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (start_offset == $past(reg_wdata[OFFS_W-1:0])));
endmodule

// File: tb/tb_eeprom_ldr_csr.sv
// Bench: directed corner cases plus seeded random traffic, checked every cycle
// against a cycle model computed from the requirements.
module tb_eeprom_ldr_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0, eng_done = 1'b0;
    logic        evt_chksum = 1'b0, evt_short32 = 1'b0, evt_short22 = 1'b0, evt_nack = 1'b0;
    logic        start_pulse, abort_pulse;
    logic [15:0] start_offset;

    int n_run = 0;
    int n_fail = 0;

    // Model state.
    logic [15:0] m_off;
    logic        m_run, m_ok, m_seqerr, m_sp, m_ap;
    logic [3:0]  m_err;
    logic [31:0] m_rdata;

    always #2.5 clk = ~clk;

    eeprom_ldr_csr dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_done(eng_done), .evt_chksum(evt_chksum), .evt_short32(evt_short32),
        .evt_short22(evt_short22), .evt_nack(evt_nack), .start_pulse(start_pulse),
        .abort_pulse(abort_pulse), .start_offset(start_offset)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] pack_word(logic [15:0] off, logic ok, logic run,
                                              logic busy, logic [3:0] err);
        logic [31:0] w;
        w = '0;
        w[15:0] = off;
        w[21] = ok;
        w[22] = run | busy;
        w[26:23] = err;
        return w;
    endfunction

    task automatic model_reset();
        m_off = '0; m_run = 0; m_ok = 0; m_seqerr = 0; m_sp = 0; m_ap = 0;
        m_err = '0; m_rdata = '0;
    endtask

    // Compares every output with the model.
    task automatic compare_all();
        chk("R1 offset out", {16'h0, start_offset}, {16'h0, m_off});
        chk("R2 start pulse", {31'h0, start_pulse}, {31'h0, m_sp});
        chk("R3 abort pulse", {31'h0, abort_pulse}, {31'h0, m_ap});
        chk("R1 rdata offset", {16'h0, reg_rdata[15:0]}, {16'h0, m_rdata[15:0]});
        chk("R4 rdata reserved", {reg_rdata[31:27], reg_rdata[20:16]}, '0);
        chk("R6 rdata success", {31'h0, reg_rdata[21]}, {31'h0, m_rdata[21]});
        chk("R5 rdata in progress", {31'h0, reg_rdata[22]}, {31'h0, m_rdata[22]});
        chk("R7 rdata errors", {28'h0, reg_rdata[26:23]}, {28'h0, m_rdata[26:23]});
    endtask

    // One cycle: drive inputs at the falling edge, step the model, compare at the next falling edge.
    task automatic cyc(input logic wr, input logic rd, input logic [31:0] wd,
                       input logic busy, input logic done, input logic [3:0] ev);
        logic start_c, abort_c, idle;
        reg_wr_en = wr; reg_rd_en = rd; reg_wdata = wd; eng_busy = busy; eng_done = done;
        {evt_nack, evt_short22, evt_short32, evt_chksum} = ev;
        idle    = !m_run && !busy;
        abort_c = wr && wd[20];
        start_c = wr && wd[16] && !wd[20] && idle;
        m_rdata = rd ? pack_word(m_off, m_ok, m_run, busy, m_err) : '0;
        m_sp = start_c;
        m_ap = abort_c;
        if (start_c) begin
            m_ok = 0; m_seqerr = 0;
        end else begin
            if (done && m_run && !m_seqerr && ev == 0) m_ok = 1;
            m_seqerr = m_seqerr || (ev != 0);
        end
        if (start_c) m_run = 1;
        else if (abort_c || done) m_run = 0;
        m_err = (rd ? 4'h0 : m_err) | ev;
        if (wr) m_off = wd[15:0];
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_cyc();
        cyc(0, 0, '0, 0, 0, 4'h0);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset rdata", reg_rdata, '0);
        chk("R1 reset offset", {16'h0, start_offset}, '0);

        // Reset-state read.
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R10 reset read", reg_rdata, '0);

        // Offset write with no command, then readback.
        cyc(1, 0, 32'h0000_BEEF, 0, 0, 4'h0);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R1 offset readback", reg_rdata, 32'h0000_BEEF);
        idle_cyc();
        chk("R10 rdata idle zero", reg_rdata, '0);

        // Start with a new offset, then a clean finish.
        cyc(1, 0, 32'h0001_0123, 0, 0, 4'h0);
        chk("R2 start pulse", {31'h0, start_pulse}, 32'h1);
        chk("R1 offset with start", {16'h0, start_offset}, 32'h0123);
        idle_cyc();
        chk("R2 pulse one cycle", {31'h0, start_pulse}, '0);
        cyc(0, 1, '0, 1, 0, 4'h0);
        chk("R5 in progress", {31'h0, reg_rdata[22]}, 32'h1);
        cyc(0, 0, '0, 0, 1, 4'h0);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R6 success set", {31'h0, reg_rdata[21]}, 32'h1);
        chk("R5 in progress dropped", {31'h0, reg_rdata[22]}, '0);

        // A start while running is ignored and keeps success.
        cyc(1, 0, 32'h0001_0010, 1, 0, 4'h0);
        chk("R9 no pulse when busy", {31'h0, start_pulse}, '0);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R9 success kept", {31'h0, reg_rdata[21]}, 32'h1);

        // Start and abort in one write: abort wins.
        cyc(1, 0, 32'h0011_0020, 0, 0, 4'h0);
        chk("R3 abort pulse", {31'h0, abort_pulse}, 32'h1);
        chk("R3 start suppressed", {31'h0, start_pulse}, '0);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R4 command bits read zero", {27'h0, reg_rdata[20:16]}, '0);

        // Abort ends a running sequence.
        cyc(1, 0, 32'h0001_0000, 0, 0, 4'h0);
        cyc(1, 0, 32'h0010_0000, 0, 0, 4'h0);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R3 abort ends run", {31'h0, reg_rdata[22]}, '0);
        chk("R6 no success after abort", {31'h0, reg_rdata[21]}, '0);

        // Error strobe in the done cycle: no success.
        cyc(1, 0, 32'h0001_0000, 0, 0, 4'h0);
        cyc(0, 0, '0, 0, 1, 4'h8);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R6 error blocks success", {31'h0, reg_rdata[21]}, '0);
        chk("R7 nack flag", {28'h0, reg_rdata[26:23]}, 32'h8);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R7 cleared by read", {28'h0, reg_rdata[26:23]}, '0);

        // Strobe arriving with a read stays set.
        cyc(0, 0, '0, 0, 0, 4'h1);
        cyc(0, 1, '0, 0, 0, 4'h1);
        chk("R8 read shows flag", {28'h0, reg_rdata[26:23]}, 32'h1);
        cyc(0, 1, '0, 0, 0, 4'h0);
        chk("R8 flag kept across read", {28'h0, reg_rdata[26:23]}, 32'h1);
        cyc(0, 1, '0, 0, 0, 4'h6);
        chk("R7 flag cleared", {28'h0, reg_rdata[26:23]}, '0);

        // Random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            logic wr, rd, busy, done;
            logic [31:0] wd;
            logic [3:0] ev;
            wr   = ($urandom % 4) == 0;
            rd   = ($urandom % 3) == 0;
            wd   = $urandom;
            wd[16] = ($urandom % 2) == 0;
            wd[20] = ($urandom % 6) == 0;
            busy = ($urandom % 5) == 0;
            done = ($urandom % 6) == 0;
            ev   = '0;
            for (int k = 0; k < 4; k++) ev[k] = ($urandom % 20) == 0;
            cyc(wr, rd, wd, busy, done, ev);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule